// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block is the receive half of a 16550-style serial channel. A bit-level receiver hands it each deserialized character, together with parity-error, framing-error and break flags. The block stores each character and its flags in a 256-deep queue. A host reads the characters back through a small synchronous register port. The same port gives a line-status byte whose error bits describe the character at the head of the queue, not the one that arrived last.

The host programs the receive trigger level, the interrupt enables and an output gate for the interrupt, and it can flush the queue. The block raises an interrupt request when enough characters are waiting or when a line error needs attention. A break that lasts several character times enters the queue as one zero character. An overrun discards the arriving character and leaves a sticky flag.

Register map (3-bit address): 0 = receive data (read pops the head), 1 = interrupt enable (bit 0 data-level request, bit 2 line-status request), 2 = queue control (write only: bit 1 flush, bits 7:6 trigger code), 4 = modem control (bit 3 gates the interrupt output), 5 = line status (read only). Line-status bits are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 and 6 always 1 (transmit side idle), 7 always 0.

Top module: `rx_status_fifo`

## Requirements
- R1: Up to 256 characters are held, and the host reads them back in arrival order; the occupancy never exceeds 256.
- R2: Trigger code 00/01/10/11 (queue-control bits 7:6) selects 8/16/56/60 characters. With interrupt-enable bit 0 set, the data-level request is active while the occupancy is at or above the level, and it drops as soon as the occupancy falls below the level.
- R3: Line-status bit 0 is 1 whenever at least one character is stored, and it returns to 0 after the host reads the last character.
- R4: Line-status bits 2 (parity), 3 (framing) and 4 (break) show the flags of the character at the head of the queue, and they are 0 when the queue is empty.
- R5: A break stores one 0x00 character with the break flag, whatever data comes with it. Further break characters are ignored until a character without the break flag arrives.
- R6: A character that arrives while 256 are stored is discarded, the stored data is left unchanged, and line-status bit 1 is set. It stays set until a line-status read, and that read clears it.
- R7: An overrun that occurs in the same cycle as a line-status read is not shown by that read. It is reported by the next line-status read.
- R8: After reset the line status reads 0x60, the interrupt output is 0 and the queue is empty.
- R9: With interrupt-enable bit 2 set, a pending overrun or an error or break flag on the head character requests an interrupt.
- R10: The interrupt output is 1 only while modem-control bit 3 is 1.
- R11: A queue-control write with bit 1 set empties the queue in one cycle. Every queue-control write loads the trigger code from bits 7:6 of the written value.
- R12: A data read from an empty queue returns 0x00 and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | One-cycle strobe: a received character is present |
| chData | input | 8 | Received character |
| chParityErr | input | 1 | Parity error for this character |
| chFrameErr | input | 1 | Framing error for this character |
| chBreak | input | 1 | Character is a break interval |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects take place at the clock edge) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid in the cycle of regRdEn |
| irqOut | output | 1 | Interrupt request |

## Verification
The trigger logic is driven with fills that stop one character short of each of the four levels and fills that land exactly on them. This separates an off-by-one in the comparison from a wrong entry in the level decode. Mixed sequences of clean, parity-error and repeated-break characters show whether the error bits follow the head of the queue or the newest arrival, and whether a long break collapses to one entry. A full queue is hit by extra characters, once alone and once in the same cycle as a status read. These cases tell sticky-flag timing apart from lost events and from corrupted stored data.

// File: rtl/rx_status_fifo_pkg.sv
package rx_status_fifo_pkg;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_IEN   = 3'd1;
  localparam logic [2:0] ADDR_QCTL  = 3'd2;
  localparam logic [2:0] ADDR_MCTL  = 3'd4;
  localparam logic [2:0] ADDR_LSTAT = 3'd5;

  typedef struct packed {
    logic       brk;
    logic       frmErr;
    logic       parErr;
    logic [7:0] data;
  } entry_t;

  typedef struct packed {
    logic   push;
    logic   pop;
    logic   flush;
    entry_t entry;
  } qCmd_t;

  function automatic logic [8:0] trigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   trigLevel = 9'd8;
      2'b01:   trigLevel = 9'd16;
      2'b10:   trigLevel = 9'd56;
      default: trigLevel = 9'd60;
    endcase
  endfunction

endpackage

// File: rtl/rxsf_datapath.sv
module rxsf_datapath
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  qCmd_t         cmd,
  output logic [CW-1:0] count,
  output entry_t        headEntry
);

  entry_t        mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          full;
  logic          doPush;
  logic          doPop;

  assign full   = (count == CW'(DEPTH));
  assign doPush = cmd.push && !full && !cmd.flush;
  assign doPop  = cmd.pop && (count != '0) && !cmd.flush;
  assign headEntry = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cmd.entry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R1: occupancy bounded by depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)) else $error("count above depth");

  // R11: flush empties the queue in one cycle
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> (count == '0)) else $error("flush did not empty");

  // R6: push into a full queue without a pop leaves occupancy unchanged
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && full && !cmd.pop && !cmd.flush) |=> $stable(count))
    else $error("push accepted while full");

endmodule

// File: rtl/rxsf_control.sv
module rxsf_control
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chValid,
  input  logic [7:0]    chData,
  input  logic          chParityErr,
  input  logic          chFrameErr,
  input  logic          chBreak,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [2:0]    regAddr,
  input  logic [7:0]    regWrData,
  input  logic [CW-1:0] count,
  input  entry_t        headEntry,
  output qCmd_t         cmd,
  output logic [7:0]    regRdData,
  output logic          irqOut
);

  logic [7:0]    ienReg;
  logic [7:0]    mctlReg;
  logic [1:0]    trigSel;
  logic          overrunFlag;
  logic          inBreak;
  logic          charEvent;
  logic          flushReq;
  logic          dataRd;
  logic          lstatRd;
  logic          notEmpty;
  logic          full;
  logic          ovfEvent;
  logic          headErr;
  logic          rxReq;
  logic          lineReq;
  logic [7:0]    lstat;
  logic [CW-1:0] trigCount;

  assign charEvent = chValid && !(chBreak && inBreak);
  assign flushReq  = regWrEn && (regAddr == ADDR_QCTL) && regWrData[1];
  assign dataRd    = regRdEn && (regAddr == ADDR_DATA);
  assign lstatRd   = regRdEn && (regAddr == ADDR_LSTAT);
  assign notEmpty  = (count != '0);
  assign full      = (count == CW'(DEPTH));
  assign ovfEvent  = charEvent && full && !flushReq;

  always_comb begin
    cmd.push         = charEvent;
    cmd.pop          = dataRd;
    cmd.flush        = flushReq;
    cmd.entry.data   = chBreak ? 8'h00 : chData;
    cmd.entry.parErr = chParityErr;
    cmd.entry.frmErr = chFrameErr;
    cmd.entry.brk    = chBreak;
  end

  assign headErr = notEmpty && (headEntry.parErr || headEntry.frmErr || headEntry.brk);
  assign lstat = {1'b0, 2'b11,
                  notEmpty && headEntry.brk,
                  notEmpty && headEntry.frmErr,
                  notEmpty && headEntry.parErr,
                  overrunFlag, notEmpty};

  assign trigCount = CW'(trigLevel(trigSel));
  assign rxReq     = ienReg[0] && (count >= trigCount);
  assign lineReq   = ienReg[2] && (overrunFlag || headErr);
  assign irqOut    = mctlReg[3] && (rxReq || lineReq);

  always_comb begin
    case (regAddr)
      ADDR_DATA:  regRdData = notEmpty ? headEntry.data : 8'h00;
      ADDR_IEN:   regRdData = ienReg;
      ADDR_MCTL:  regRdData = mctlReg;
      ADDR_LSTAT: regRdData = lstat;
      default:    regRdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg      <= '0;
      mctlReg     <= '0;
      trigSel     <= '0;
      overrunFlag <= 1'b0;
      inBreak     <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_IEN)  ienReg  <= regWrData;
      if (regWrEn && regAddr == ADDR_MCTL) mctlReg <= regWrData;
      if (regWrEn && regAddr == ADDR_QCTL) trigSel <= regWrData[7:6];
      if (ovfEvent)     overrunFlag <= 1'b1;
      else if (lstatRd) overrunFlag <= 1'b0;
      if (chValid) inBreak <= chBreak;
    end
  end

  // R3: reading the last character clears data ready
  assert_ready_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && count == CW'(1) && !chValid && !flushReq) |=> !lstat[0])
    else $error("data ready stuck");

  // R5: a repeated break character does not change occupancy
  assert_break_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chValid && chBreak && inBreak && !regRdEn && !regWrEn) |=> $stable(count))
    else $error("repeated break stored");

  // R7: an overrun raised during a status read shows up afterwards
  assert_overrun_late_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chValid && !chBreak && full && lstatRd && !regWrEn) |=> lstat[1])
    else $error("overrun lost during status read");

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chValid,
  input  logic [7:0] chData,
  input  logic       chParityErr,
  input  logic       chFrameErr,
  input  logic       chBreak,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqOut
);

  localparam int CW = $clog2(DEPTH) + 1;

  qCmd_t         cmd;
  logic [CW-1:0] count;
  entry_t        headEntry;

  rxsf_control #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .chValid(chValid), .chData(chData), .chParityErr(chParityErr),
    .chFrameErr(chFrameErr), .chBreak(chBreak),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .count(count), .headEntry(headEntry),
    .cmd(cmd), .regRdData(regRdData), .irqOut(irqOut)
  );

  rxsf_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count), .headEntry(headEntry)
  );

endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       chValid, chParityErr, chFrameErr, chBreak;
  logic [7:0] chData;
  logic       regWrEn, regRdEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       irqOut;

  int total = 0;
  int bad   = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  rx_status_fifo uut (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .chParityErr(chParityErr), .chFrameErr(chFrameErr), .chBreak(chBreak),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // {trigger code, expected irq, characters pushed}
  localparam logic [11:0] VEC [10] = '{
    {2'b00, 1'b0, 9'd7},  {2'b00, 1'b1, 9'd8},
    {2'b01, 1'b0, 9'd15}, {2'b01, 1'b1, 9'd16},
    {2'b10, 1'b0, 9'd55}, {2'b10, 1'b1, 9'd56},
    {2'b11, 1'b0, 9'd59}, {2'b11, 1'b1, 9'd60},
    {2'b00, 1'b0, 9'd0},  {2'b11, 1'b1, 9'd61}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pushChar(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    chValid = 1'b1; chData = d; chParityErr = p; chFrameErr = f; chBreak = b;
    @(negedge clk);
    chValid = 1'b0; chParityErr = 1'b0; chFrameErr = 1'b0; chBreak = 1'b0;
  endtask

  task automatic pushN(input int n);
    for (int i = 0; i < n; i++) pushChar(8'(i), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errs;
    rstN = 1'b0; chValid = 0; chData = 0; chParityErr = 0; chFrameErr = 0; chBreak = 0;
    regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    regRead(3'd5, rd); chk("R8 lstat", rd, 8'h60);
    chk("R8 irq", {7'd0, irqOut}, 8'h00);
    // R12 read of empty queue
    regRead(3'd0, rd); chk("R12 empty data", rd, 8'h00);
    regRead(3'd5, rd); chk("R12 still empty", rd, 8'h60);

    // R2 trigger table
    regWrite(3'd1, 8'h01); regWrite(3'd4, 8'h08);
    foreach (VEC[v]) begin
      regWrite(3'd2, {VEC[v][11:10], 6'b000010});
      pushN(int'(VEC[v][8:0]));
      chk("R2 level irq", {7'd0, irqOut}, {7'd0, VEC[v][9]});
      regRead(3'd5, rd);
      chk("R3 data ready", {7'd0, rd[0]}, {7'd0, VEC[v][8:0] != 0});
    end
    // last vector holds 61 at level 60: two pops go below the level
    regRead(3'd0, rd); chk("R1 order first", rd, 8'h00);
    chk("R2 at level", {7'd0, irqOut}, 8'h01);
    regRead(3'd0, rd); chk("R1 order second", rd, 8'h01);
    chk("R2 below level", {7'd0, irqOut}, 8'h00);

    // R11 flush with new trigger code
    regWrite(3'd2, 8'h02); pushN(10);
    chk("R11 pre irq", {7'd0, irqOut}, 8'h01);
    regWrite(3'd2, 8'h42);
    chk("R11 irq after flush", {7'd0, irqOut}, 8'h00);
    regRead(3'd5, rd); chk("R11 empty", rd, 8'h60);
    pushN(15); chk("R11 level16 short", {7'd0, irqOut}, 8'h00);
    pushN(1);  chk("R11 level16 hit", {7'd0, irqOut}, 8'h01);
    regWrite(3'd2, 8'h02);

    // R3 and R4 and R5: head flags and break collapse
    regWrite(3'd1, 8'h00);
    pushChar(8'h31, 0, 0, 0);
    pushChar(8'h55, 0, 0, 1); pushChar(8'h66, 0, 0, 1); pushChar(8'h77, 0, 0, 1);
    pushChar(8'h41, 0, 0, 0);
    pushChar(8'h52, 1, 0, 0);
    regRead(3'd5, rd); chk("R4 clean head", rd, 8'h61);
    regRead(3'd0, rd); chk("R1 data", rd, 8'h31);
    regRead(3'd5, rd); chk("R4 break at head", rd, 8'h71);
    regRead(3'd0, rd); chk("R5 zero char", rd, 8'h00);
    regRead(3'd5, rd); chk("R5 one break entry", rd, 8'h61);
    regRead(3'd0, rd); chk("R5 next char", rd, 8'h41);
    regRead(3'd5, rd); chk("R4 parity head", rd, 8'h65);
    chk("R9 masked", {7'd0, irqOut}, 8'h00);
    regWrite(3'd1, 8'h04);
    chk("R9 line irq", {7'd0, irqOut}, 8'h01);
    regWrite(3'd4, 8'h00);
    chk("R10 gated", {7'd0, irqOut}, 8'h00);
    regWrite(3'd4, 8'h08);
    regRead(3'd0, rd); chk("R4 parity data", rd, 8'h52);
    chk("R9 cleared", {7'd0, irqOut}, 8'h00);
    regRead(3'd5, rd); chk("R3 drained", rd, 8'h60);

    // R6 and R7 overrun
    regWrite(3'd1, 8'h00);
    pushN(256);
    regRead(3'd5, rd); chk("R1 full", rd, 8'h61);
    pushChar(8'hEE, 0, 0, 0);
    regRead(3'd5, rd); chk("R6 overrun set", rd, 8'h63);
    regRead(3'd5, rd); chk("R6 overrun cleared", rd, 8'h61);
    @(negedge clk);
    chValid = 1'b1; chData = 8'hEF; regRdEn = 1'b1; regAddr = 3'd5;
    #1 rd = regRdData;
    @(negedge clk);
    chValid = 1'b0; regRdEn = 1'b0;
    chk("R7 held off", rd, 8'h61);
    regRead(3'd5, rd); chk("R7 next read", rd, 8'h63);
    pushChar(8'hF0, 0, 0, 0);
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      regRead(3'd0, rd);
      if (rd !== 8'(i)) errs++;
    end
    chk("R6 data intact", 8'(errs), 8'h00);
    regRead(3'd5, rd); chk("R6 sticky", rd, 8'h62);
    regRead(3'd5, rd); chk("R6 cleared", rd, 8'h60);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule